// File: doc/BRIEF.md
# Last-Level Cache Error Capture and Injection

This block sits beside a shared last-level cache and keeps the error state that the cache's ECC checkers and tag-parity checkers report. Each reported event carries the requester that caused the access, the kind of transaction, the error class, the byte address, the set index and the way. The block counts correctable and uncorrectable errors in two saturating 16-bit fields of a single counter word. It records the full details of the first error that software has not yet acknowledged, and keeps them until software clears the valid flag.

For testing, an injection unit can corrupt one write to the data array. Software loads a 32-bit XOR mask and then arms a control word that holds a line address and an enable bit. The next array write to that line leaves the block with the mask XORed into its data. The enable bit then clears itself, so each arming injects exactly one error. All state is reached through a simple 32-bit register port that reads combinationally and writes on the clock edge.

Register word indices: 0 counter, 1 attribute capture, 2 address capture, 3 way capture, 4 injection mask, 5 injection control. Indices 6 and 7 read as zero and ignore writes.

Top module: `llc_err_monitor`

## Requirements
- R1: After reset every register word reads zero, `inj_hit_o` is 0 and `arr_wdata_o` equals `arr_wdata_i`.
- R2: An event with class 0 (correctable ECC) adds one to the correctable field, word 0 bits 15:0. Class 1 (uncorrectable ECC) and class 2 (tag parity) add one to the uncorrectable field, word 0 bits 31:16. Class 3 is reserved: it is neither counted nor captured.
- R3: Each counter field saturates at 0xFFFF and stays there under further events of its class.
- R4: A write to word 0 with bit 0 set clears both fields. A write to word 0 with bit 0 clear has no effect. An event in the same cycle as a clear is counted on top of the cleared value.
- R5: When the valid flag is clear, a counted event is captured. Word 1 then holds valid at bit 0, source at bits 10:8 (0 to 3 name a CPU, larger values an I/O requester), transaction at bits 14:12 (0 data read, 1 instruction fetch, 2 clean/flush, 3 eviction, 4 read-modify-write) and class at bits 17:16. Word 2 holds the address. Word 3 holds the way at bits 3:0 and the set index at bits 17:8.
- R6: While valid is set, later events are counted but leave words 1 to 3 unchanged.
- R7: Writing word 1 with bit 0 set clears valid and keeps the captured fields. Writing bit 0 clear has no effect. An event in the same cycle as the clear is counted but not captured.
- R8: Word 4 holds the 32-bit injection mask and reads back as written. Word 5 keeps only the line address (bits 31:5) and the enable bit (bit 0). Its other bits read as zero.
- R9: While enable is set, an array write whose address bits 31:5 equal the armed line drives `arr_wdata_o` = `arr_wdata_i` XOR mask and raises `inj_hit_o` in the same cycle. Otherwise the data passes through unchanged.
- R10: After one injection the enable bit reads 0 and later matching writes pass unchanged. An array read (`arr_we_i` low) to the armed line neither injects nor disarms.
- R11: An array write to a different line neither injects nor clears the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_vld_i | input | 1 | Error event strobe |
| evt_src_i | input | 3 | Requester of the failing access |
| evt_txn_i | input | 3 | Transaction type |
| evt_cls_i | input | 2 | Error class |
| evt_addr_i | input | ADDR_W | Failing byte address |
| evt_set_i | input | IDX_W | Set index |
| evt_way_i | input | WAY_W | Way number |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| arr_we_i | input | 1 | Data array access is a write |
| arr_addr_i | input | ADDR_W | Data array access address |
| arr_wdata_i | input | 32 | Write data from the cache pipeline |
| arr_wdata_o | output | 32 | Write data toward the data array |
| inj_hit_o | output | 1 | Mask applied to this write |

## Verification
The assertions assume that `evt_vld_i`, `reg_we_i` and `arr_we_i` are known once reset is released, and that at most one event arrives per cycle. Several of them also assume that a counter clear, a capture acknowledge or a control write may coincide with an event or an array write, and they exclude only those cycles where the stated outcome would change. The random stimulus drives at most one event and one register write per cycle, both away from the clock edge. It mixes all four class codes and draws acknowledges and clears with bit 0 set and with bit 0 clear. Array addresses come from a few neighbouring lines, so matches, misses and reads to the armed line all occur often.

// File: rtl/llc_err_pkg.sv
package llc_err_pkg;
  typedef enum logic [1:0] {
    CLS_CORR   = 2'd0,
    CLS_UNCORR = 2'd1,
    CLS_TAG    = 2'd2,
    CLS_RSVD   = 2'd3
  } err_cls_e;

  typedef struct packed {
    logic [2:0] src;
    logic [2:0] txn;
    err_cls_e   cls;
  } err_attr_t;

  localparam int unsigned REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] RI_CNT   = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_ATTR  = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_CADDR = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_CWAY  = 3'd3;
  localparam logic [REG_IDX_W-1:0] RI_IMASK = 3'd4;
  localparam logic [REG_IDX_W-1:0] RI_ICTL  = 3'd5;

  localparam int unsigned CNT_W        = 16;
  localparam int unsigned ATTR_SRC_LSB = 8;
  localparam int unsigned ATTR_TXN_LSB = 12;
  localparam int unsigned ATTR_CLS_LSB = 16;
  localparam int unsigned WAY_IDX_LSB  = 8;
endpackage

// File: rtl/llc_err_sat_cnt.sv
module llc_err_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, base, cnt_d;

  // clear first, then count the coincident event
  always_comb begin
    base  = clr_i ? '0 : cnt_q;
    cnt_d = base;
    if (inc_i && (base != {W{1'b1}})) cnt_d = base + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/llc_err_capture.sv
module llc_err_capture
  import llc_err_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 10,
  parameter int unsigned WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  err_attr_t     attr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [IW-1:0] set_i,
  input  logic [WW-1:0] way_i,
  input  logic          ack_i,
  output logic          vld_o,
  output err_attr_t     attr_o,
  output logic [AW-1:0] addr_o,
  output logic [IW-1:0] set_o,
  output logic [WW-1:0] way_o
);
  logic          vld_q;
  err_attr_t     attr_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] set_q;
  logic [WW-1:0] way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      attr_q <= '0;
      addr_q <= '0;
      set_q  <= '0;
      way_q  <= '0;
    end else if (vld_q) begin
      if (ack_i) vld_q <= 1'b0;
    end else if (evt_i) begin
      vld_q  <= 1'b1;
      attr_q <= attr_i;
      addr_q <= addr_i;
      set_q  <= set_i;
      way_q  <= way_i;
    end
  end

  assign vld_o  = vld_q;
  assign attr_o = attr_q;
  assign addr_o = addr_q;
  assign set_o  = set_q;
  assign way_o  = way_q;
endmodule

// File: rtl/llc_err_inject.sv
module llc_err_inject #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned LINE_LSB = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic [DW-1:0] mask_wdata_i,
  input  logic          ctl_we_i,
  input  logic [AW-1:0] ctl_wdata_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] wr_data_o,
  output logic          hit_o,
  output logic          en_o,
  output logic [DW-1:0] mask_o,
  output logic [AW-1:0] ctl_rd_o
);
  localparam int unsigned LINE_W = AW - LINE_LSB;

  logic              en_q;
  logic [LINE_W-1:0] line_q;
  logic [DW-1:0]     mask_q;
  logic              hit;
  logic              unused_ctl;

  assign unused_ctl = ^{ctl_wdata_i[LINE_LSB-1:1], wr_addr_i[LINE_LSB-1:0]};
  assign hit = en_q && wr_i && (wr_addr_i[AW-1:LINE_LSB] == line_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      line_q <= '0;
      mask_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (ctl_we_i) begin
        en_q   <= ctl_wdata_i[0];
        line_q <= ctl_wdata_i[AW-1:LINE_LSB];
      end else if (hit) begin
        en_q   <= 1'b0;  // one error per arm
      end
    end
  end

  always_comb begin
    ctl_rd_o                 = '0;
    ctl_rd_o[AW-1:LINE_LSB]  = line_q;
    ctl_rd_o[0]              = en_q;
  end

  assign wr_data_o = hit ? (wr_data_i ^ mask_q) : wr_data_i;
  assign hit_o     = hit;
  assign en_o      = en_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/llc_err_monitor.sv
module llc_err_monitor
  import llc_err_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned WAY_W    = 4,
  parameter int unsigned LINE_LSB = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_vld_i,
  input  logic [2:0]        evt_src_i,
  input  logic [2:0]        evt_txn_i,
  input  logic [1:0]        evt_cls_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic [IDX_W-1:0]  evt_set_i,
  input  logic [WAY_W-1:0]  evt_way_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              arr_we_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic [31:0]       arr_wdata_i,
  output logic [31:0]       arr_wdata_o,
  output logic              inj_hit_o
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_CNT  = 2;

  err_cls_e          evt_cls;
  logic              evt_ok;
  logic              cnt_clr, cap_ack, mask_we, ctl_we;
  logic [N_CNT-1:0]  cnt_inc;
  logic [CNT_W-1:0]  cnt_val [N_CNT];
  logic [CNT_W-1:0]  ce_cnt, ue_cnt;
  err_attr_t         evt_attr, cap_attr;
  logic              cap_vld;
  logic [ADDR_W-1:0] cap_addr;
  logic [IDX_W-1:0]  cap_set;
  logic [WAY_W-1:0]  cap_way;
  logic              inj_en;
  logic [DATA_W-1:0] inj_mask;
  logic [ADDR_W-1:0] inj_ctl_rd;

  assign evt_cls = err_cls_e'(evt_cls_i);
  assign evt_ok  = evt_vld_i && (evt_cls != CLS_RSVD);

  assign cnt_clr = reg_we_i && (reg_idx_i == RI_CNT)   && reg_wdata_i[0];
  assign cap_ack = reg_we_i && (reg_idx_i == RI_ATTR)  && reg_wdata_i[0];
  assign mask_we = reg_we_i && (reg_idx_i == RI_IMASK);
  assign ctl_we  = reg_we_i && (reg_idx_i == RI_ICTL);

  assign cnt_inc[0] = evt_ok && (evt_cls == CLS_CORR);
  assign cnt_inc[1] = evt_ok && (evt_cls != CLS_CORR);

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    llc_err_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc[g]),
      .cnt_o  (cnt_val[g])
    );
  end

  assign ce_cnt = cnt_val[0];
  assign ue_cnt = cnt_val[1];

  assign evt_attr = '{src: evt_src_i, txn: evt_txn_i, cls: evt_cls};

  llc_err_capture #(.AW(ADDR_W), .IW(IDX_W), .WW(WAY_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_ok),
    .attr_i (evt_attr),
    .addr_i (evt_addr_i),
    .set_i  (evt_set_i),
    .way_i  (evt_way_i),
    .ack_i  (cap_ack),
    .vld_o  (cap_vld),
    .attr_o (cap_attr),
    .addr_o (cap_addr),
    .set_o  (cap_set),
    .way_o  (cap_way)
  );

  llc_err_inject #(.AW(ADDR_W), .DW(DATA_W), .LINE_LSB(LINE_LSB)) u_inj (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (mask_we),
    .mask_wdata_i (reg_wdata_i),
    .ctl_we_i     (ctl_we),
    .ctl_wdata_i  (reg_wdata_i[ADDR_W-1:0]),
    .wr_i         (arr_we_i),
    .wr_addr_i    (arr_addr_i),
    .wr_data_i    (arr_wdata_i),
    .wr_data_o    (arr_wdata_o),
    .hit_o        (inj_hit_o),
    .en_o         (inj_en),
    .mask_o       (inj_mask),
    .ctl_rd_o     (inj_ctl_rd)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      RI_CNT:   reg_rdata_o = {ue_cnt, ce_cnt};
      RI_ATTR: begin
        reg_rdata_o[0]                  = cap_vld;
        reg_rdata_o[ATTR_SRC_LSB +: 3]  = cap_attr.src;
        reg_rdata_o[ATTR_TXN_LSB +: 3]  = cap_attr.txn;
        reg_rdata_o[ATTR_CLS_LSB +: 2]  = cap_attr.cls;
      end
      RI_CADDR: reg_rdata_o[ADDR_W-1:0] = cap_addr;
      RI_CWAY: begin
        reg_rdata_o[WAY_W-1:0]              = cap_way;
        reg_rdata_o[WAY_IDX_LSB +: IDX_W]   = cap_set;
      end
      RI_IMASK: reg_rdata_o = inj_mask;
      RI_ICTL:  reg_rdata_o[ADDR_W-1:0] = inj_ctl_rd;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/llc_err_monitor_chk.sv
module llc_err_monitor_chk
  import llc_err_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_vld_i,
  input logic [1:0]       evt_cls_i,
  input logic             reg_we_i,
  input logic [2:0]       reg_idx_i,
  input logic [31:0]      reg_wdata_i,
  input logic             arr_we_i,
  input logic [31:0]      arr_wdata_i,
  input logic [31:0]      arr_wdata_o,
  input logic             inj_hit_o,
  input logic [CNT_W-1:0] ce_cnt,
  input logic [CNT_W-1:0] ue_cnt,
  input logic             cap_vld,
  input err_attr_t        cap_attr,
  input logic             inj_en
);
  logic clr_w, ack_w, ctl_w, evt_ok, unused_w;

  assign clr_w    = reg_we_i && (reg_idx_i == RI_CNT)  && reg_wdata_i[0];
  assign ack_w    = reg_we_i && (reg_idx_i == RI_ATTR) && reg_wdata_i[0];
  assign ctl_w    = reg_we_i && (reg_idx_i == RI_ICTL);
  assign evt_ok   = evt_vld_i && (evt_cls_i != 2'd3);
  assign unused_w = ^reg_wdata_i[31:1];

  assert_ce_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_w |=> (ce_cnt == $past(ce_cnt)) || (ce_cnt == $past(ce_cnt) + 1'b1));

  assert_rsvd_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld_i && (evt_cls_i == 2'd3) && !clr_w && !cap_vld |=>
      $stable(ce_cnt) && $stable(ue_cnt) && !cap_vld);

  assert_ce_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_cnt == {CNT_W{1'b1}}) && !clr_w |=> ce_cnt == {CNT_W{1'b1}});

  assert_ue_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_cnt == {CNT_W{1'b1}}) && !clr_w |=> ue_cnt == {CNT_W{1'b1}});

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w && !evt_vld_i |=> (ce_cnt == '0) && (ue_cnt == '0));

  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_vld && evt_ok |=> cap_vld);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_vld && !ack_w |=> cap_vld && $stable(cap_attr));

  assert_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_vld && ack_w |=> !cap_vld);

  assert_hit_needs_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_hit_o |-> arr_we_i && inj_en);

  assert_pass_through_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_hit_o |-> arr_wdata_o == arr_wdata_i);

  assert_one_shot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_hit_o && !ctl_w |=> !inj_en);

  assert_stay_armed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_en && !inj_hit_o && !ctl_w |=> inj_en);
endmodule

bind llc_err_monitor llc_err_monitor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_vld_i   (evt_vld_i),
  .evt_cls_i   (evt_cls_i),
  .reg_we_i    (reg_we_i),
  .reg_idx_i   (reg_idx_i),
  .reg_wdata_i (reg_wdata_i),
  .arr_we_i    (arr_we_i),
  .arr_wdata_i (arr_wdata_i),
  .arr_wdata_o (arr_wdata_o),
  .inj_hit_o   (inj_hit_o),
  .ce_cnt      (ce_cnt),
  .ue_cnt      (ue_cnt),
  .cap_vld     (cap_vld),
  .cap_attr    (cap_attr),
  .inj_en      (inj_en)
);

// File: tb/llc_err_monitor_tb.sv
`timescale 1ns/100ps
module llc_err_monitor_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_vld_i = 1'b0;
  logic [2:0]  evt_src_i = '0;
  logic [2:0]  evt_txn_i = '0;
  logic [1:0]  evt_cls_i = '0;
  logic [31:0] evt_addr_i = '0;
  logic [9:0]  evt_set_i = '0;
  logic [3:0]  evt_way_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        arr_we_i = 1'b0;
  logic [31:0] arr_addr_i = '0;
  logic [31:0] arr_wdata_i = '0;
  logic [31:0] arr_wdata_o;
  logic        inj_hit_o;

  llc_err_monitor dut_i (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  int n_cmp = 0, n_bad = 0;
  int m_ce = 0, m_ue = 0;
  logic        m_vld = 1'b0;
  logic [31:0] m_attr = '0, m_addr = '0, m_way = '0, m_mask = '0, m_ctl = '0;

  function automatic logic [31:0] attr_word(input logic [2:0] s, input logic [2:0] t,
                                            input logic [1:0] c);
    return (32'(s) << 8) | (32'(t) << 12) | (32'(c) << 16);
  endfunction

  function automatic logic [31:0] way_word(input logic [9:0] st, input logic [3:0] w);
    return (32'(st) << 8) | 32'(w);
  endfunction

  function automatic logic [31:0] cnt_word();
    return {m_ue[15:0], m_ce[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] idx, input string req, input logic [31:0] exp);
    reg_idx_i = idx;
    #0.5;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
    evt_vld_i = 1'b0;
    reg_we_i  = 1'b0;
    arr_we_i  = 1'b0;
  endtask

  // drive one event and/or one register write, update the model, advance one clock
  task automatic apply(input logic ev, input logic [2:0] s, input logic [2:0] t,
                       input logic [1:0] c, input logic [31:0] a, input logic [9:0] st,
                       input logic [3:0] w, input logic we, input logic [2:0] idx,
                       input logic [31:0] wd);
    logic ok, clr, ack;
    evt_vld_i = ev; evt_src_i = s; evt_txn_i = t; evt_cls_i = c;
    evt_addr_i = a; evt_set_i = st; evt_way_i = w;
    reg_we_i = we; reg_idx_i = idx; reg_wdata_i = wd;
    ok  = ev && (c != 2'd3);
    clr = we && (idx == 3'd0) && wd[0];
    ack = we && (idx == 3'd1) && wd[0];
    if (clr) begin m_ce = 0; m_ue = 0; end
    if (ok && c == 2'd0 && m_ce < 65535) m_ce++;
    if (ok && c != 2'd0 && m_ue < 65535) m_ue++;
    if (m_vld) begin
      if (ack) m_vld = 1'b0;
    end else if (ok) begin
      m_vld = 1'b1; m_attr = attr_word(s, t, c); m_addr = a; m_way = way_word(st, w);
    end
    if (we && idx == 3'd4) m_mask = wd;
    if (we && idx == 3'd5) m_ctl = wd & 32'hFFFF_FFE1;
    cyc();
  endtask

  task automatic ev(input logic [2:0] s, input logic [2:0] t, input logic [1:0] c,
                    input logic [31:0] a, input logic [9:0] st, input logic [3:0] w);
    apply(1'b1, s, t, c, a, st, w, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] wd);
    apply(1'b0, 3'd0, 3'd0, 2'd0, 32'd0, 10'd0, 4'd0, 1'b1, idx, wd);
  endtask

  task automatic chk_cap(input string req);
    rd_chk(3'd1, req, m_attr | 32'(m_vld));
    rd_chk(3'd2, req, m_addr);
    rd_chk(3'd3, req, m_way);
  endtask

  // array access: check data and hit in the same cycle, then advance
  task automatic arr(input logic we, input logic [31:0] a, input logic [31:0] d, input string req);
    logic exp_hit;
    arr_we_i = we; arr_addr_i = a; arr_wdata_i = d;
    exp_hit = m_ctl[0] && we && (a[31:5] == m_ctl[31:5]);
    #0.5;
    chk(req, 32'(inj_hit_o), 32'(exp_hit));
    chk(req, arr_wdata_o, exp_hit ? (d ^ m_mask) : d);
    cyc();
    if (exp_hit) m_ctl[0] = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    for (int i = 0; i < 8; i++) rd_chk(3'(i), "R1 reset", 32'd0);
    arr_wdata_i = 32'h1357_9BDF; #0.5;
    chk("R1 passthrough", arr_wdata_o, 32'h1357_9BDF);
    chk("R1 hit", 32'(inj_hit_o), 32'd0);

    // R2 reserved class ignored
    ev(3'd1, 3'd2, 2'd3, 32'hDEAD_0000, 10'h3FF, 4'hF);
    rd_chk(3'd0, "R2 rsvd count", 32'd0);
    rd_chk(3'd1, "R2 rsvd capture", 32'd0);

    // R5 first capture
    ev(3'd2, 3'd4, 2'd0, 32'h8000_1234, 10'h155, 4'h9);
    rd_chk(3'd0, "R2 ce", cnt_word());
    chk("R5 ref", m_attr | 32'(m_vld), 32'h0000_4201);
    chk_cap("R5 capture");

    // R6 hold while valid, R2 ue counting
    ev(3'd5, 3'd1, 2'd1, 32'h0000_0040, 10'h001, 4'h1);
    ev(3'd0, 3'd3, 2'd2, 32'h0000_0080, 10'h002, 4'h2);
    rd_chk(3'd0, "R2 ue", 32'h0002_0001);
    chk_cap("R6 hold");

    // R7 acknowledge
    wr(3'd1, 32'hFFFF_FFFE);
    chk_cap("R7 bit0 clear no effect");
    wr(3'd1, 32'h1);
    chk_cap("R7 clear");
    ev(3'd6, 3'd2, 2'd2, 32'hCAFE_F00C, 10'h2AA, 4'h3);
    chk_cap("R5 io source");
    apply(1'b1, 3'd3, 3'd0, 2'd0, 32'h0BAD_0BAD, 10'h0F0, 4'h4, 1'b1, 3'd1, 32'h1);
    chk_cap("R7 ack vs event");
    rd_chk(3'd0, "R7 event counted", cnt_word());

    // R4 counter clear
    wr(3'd0, 32'hFFFF_FFFE);
    rd_chk(3'd0, "R4 bit0 clear no effect", cnt_word());
    wr(3'd0, 32'h1);
    rd_chk(3'd0, "R4 clear", 32'd0);
    apply(1'b1, 3'd0, 3'd0, 2'd0, 32'd0, 10'd0, 4'd0, 1'b1, 3'd0, 32'h1);
    rd_chk(3'd0, "R4 clear plus event", 32'h0000_0001);

    // R3 saturation
    for (int i = 0; i < 65540; i++) ev(3'd0, 3'd0, 2'd0, 32'h100, 10'd1, 4'd1);
    rd_chk(3'd0, "R3 saturate", 32'h0000_FFFF);
    ev(3'd1, 3'd1, 2'd1, 32'h200, 10'd2, 4'd2);
    rd_chk(3'd0, "R3 other field", 32'h0001_FFFF);
    wr(3'd0, 32'h1);

    // R8 injection registers
    wr(3'd4, 32'hA5A5_0F0F);
    rd_chk(3'd4, "R8 mask", 32'hA5A5_0F0F);
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk(3'd5, "R8 ctl legal bits", 32'hFFFF_FFE1);
    wr(3'd5, 32'h0);
    wr(3'd5, 32'h1234_5661);
    rd_chk(3'd5, "R8 ctl arm", 32'h1234_5661);

    // R9..R11 injection
    arr(1'b0, 32'h1234_5660, 32'h1111_2222, "R10 read no inject");
    arr(1'b1, 32'h1234_5680, 32'h3333_4444, "R11 other line");
    rd_chk(3'd5, "R11 still armed", 32'h1234_5661);
    arr(1'b1, 32'h1234_567C, 32'h5555_6666, "R9 inject");
    rd_chk(3'd5, "R10 disarmed", 32'h1234_5660);
    arr(1'b1, 32'h1234_5664, 32'h7777_8888, "R10 second write");

    // random events and register writes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic        we;
      logic [2:0]  idx;
      r = $urandom;
      we = 1'b0; idx = 3'd0;
      if (r[2:0] == 3'd0) begin we = 1'b1; idx = 3'd0; end
      else if (r[2:0] == 3'd1) begin we = 1'b1; idx = 3'd1; end
      apply(r[3], 3'($urandom), 3'($urandom % 5), 2'($urandom), $urandom,
            10'($urandom), 4'($urandom), we, idx, {$urandom, r[4]} >> 0);
      rd_chk(3'd0, "R2 random count", cnt_word());
      chk_cap("R6 random capture");
    end

    // random injection
    for (int i = 0; i < 800; i++) begin
      int k;
      logic [31:0] a;
      k = $urandom % 6;
      a = 32'h0000_4000 + 32'(($urandom % 3) * 32) + 32'($urandom % 32);
      if (k == 0) wr(3'd5, a | 32'($urandom % 2) | ($urandom & 32'h1E));
      else if (k == 1) wr(3'd4, $urandom);
      else arr(k != 2, a, $urandom, "R9 random inject");
      if (i % 8 == 0) rd_chk(3'd5, "R10 random ctl", m_ctl);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule